// File: doc/BRIEF.md
# Converter calibration sequencer

This block is the digital control state machine that runs the calibration routines of a sigma-delta converter. A two-bit mode field selects normal running, an internal calibration, or one of two system calibration steps (offset or gain). The block counts output-rate periods for each phase and tells the modulator model which source to convert. It latches the zero-point and span-point conversion results into two coefficient registers and clears the mode field when calibration ends. It also drives an active-low data-ready line that stays high until a fresh word has been loaded.

The modulator, its front-end gain, the decimation filter and the correction arithmetic sit outside the block. They are seen only as a result bus, an output-rate tick that marks each finished filter word, and a modulator-cycle tick. Software polls the mode field to see the calibration end early, and watches data-ready to see the first valid word afterwards.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, rdy_n is 1, mode_field is 00, cal_src is 00, and zero_coef, full_coef and data_word are all zero.
- R2: With mode_field at 00 and no command accepted, each rate_tick loads conv_result into data_word and drives rdy_n to 0 at the same clock edge.
- R3: A mode_wr is accepted only while mode_field is 00 and mode_wdata is not 00. Code 01 selects internal calibration, 10 the system offset step and 11 the system gain step. A write of 00, or any write while mode_field is non-zero, leaves mode_field and the sequence unchanged.
- R4: Internal calibration converts the shorted input (cal_src 01) for 3 rate ticks, then the reference (cal_src 10) for 3 rate ticks. mode_field returns to 00 at the 6th counted rate tick.
- R5: After internal calibration, rdy_n goes to 0 and data_word takes conv_result at the 9th counted rate tick.
- R6: A system step converts the analog input (cal_src 00). mode_field returns to 00 at the 3rd counted rate tick, and rdy_n goes to 0 with a new data_word at the 4th.
- R7: conv_result at the last tick of a zero phase (internal tick 3, or offset step tick 3) goes only to zero_coef. conv_result at the last tick of a span phase (internal tick 6, or gain step tick 3) goes only to full_coef. The other coefficient register keeps its value.
- R8: After a command is accepted, rdy_n becomes 1 at the first clock edge, from the accepting edge on, at which mod_tick is high. It stays 1 until the data-ready point of R5 or R6.
- R9: A rate_tick in the same cycle as an accepted command is not counted as a period and does not load data_word.
- R10: A command written after mode_field has cleared, but before data-ready has fallen, is accepted and starts a complete new sequence, and rdy_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_tick | input | 1 | One-cycle pulse per output-rate period (filter word ready) |
| mod_tick | input | 1 | One-cycle pulse per modulator cycle |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode code to write |
| conv_result | input | DW | Conversion result from the modulator and filter model |
| mode_field | output | 2 | Current mode field |
| cal_src | output | 2 | Source to convert: 00 input, 01 shorted, 10 reference |
| rdy_n | output | 1 | Active-low data-ready |
| zero_coef | output | DW | Zero-scale calibration register |
| full_coef | output | DW | Full-scale calibration register |
| data_word | output | DW | Data register |

## Verification
The command write and the completion of a normal conversion can land in the same cycle. The bench provokes this by raising mode_wr together with rate_tick while running. It judges the result by the unchanged data_word and by the mode field clearing exactly 6 or 3 ticks later, which shows the shared tick was not counted. The command also meets the modulator tick at every phase of the modulator period. The bench sweeps the accept cycle across that period and expects rdy_n to rise on exactly the edge where mod_tick is first seen.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN       = 2'b00,
        MODE_SELF      = 2'b01,
        MODE_SYS_ZERO  = 2'b10,
        MODE_SYS_FULL  = 2'b11
    } cal_mode_e;

    typedef enum logic [1:0] {
        SRC_INPUT     = 2'b00,
        SRC_SHORT     = 2'b01,
        SRC_REFERENCE = 2'b10
    } src_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SELF_ZERO,
        PH_SELF_FULL,
        PH_SYS_ZERO,
        PH_SYS_FULL,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic data_we;
        logic full_we;
        logic zero_we;
    } reg_we_t;

    localparam int NUM_SLOTS = 3;

    function automatic src_e phase_source(phase_e p);
        case (p)
            PH_SELF_ZERO: return SRC_SHORT;
            PH_SELF_FULL: return SRC_REFERENCE;
            default:      return SRC_INPUT;
        endcase
    endfunction

    function automatic phase_e entry_phase(cal_mode_e m);
        case (m)
            MODE_SELF:     return PH_SELF_ZERO;
            MODE_SYS_ZERO: return PH_SYS_ZERO;
            MODE_SYS_FULL: return PH_SYS_FULL;
            default:       return PH_IDLE;
        endcase
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] target,
    output logic          done
);
    logic [CW-1:0] cnt;

    assign done = tick && (cnt == target - CW'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import calseq_pkg::*;
#(
    parameter int SELF_ZERO_LEN = 3,
    parameter int SELF_FULL_LEN = 3,
    parameter int SYS_LEN       = 3,
    parameter int SELF_TAIL_LEN = 3,
    parameter int SYS_TAIL_LEN  = 1,
    parameter int CW            = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rate_tick,
    input  logic          mode_wr,
    input  logic [1:0]    mode_wdata,
    input  logic          done,
    output logic          accept,
    output logic          timer_clr,
    output logic [CW-1:0] target,
    output reg_we_t       we,
    output logic [1:0]    mode_field,
    output logic [1:0]    cal_src
);
    cal_mode_e mode_q;
    phase_e    phase;
    logic      tail_self;

    assign accept     = mode_wr && (mode_q == MODE_RUN) && (mode_wdata != 2'b00);
    assign timer_clr  = accept || done;
    assign mode_field = mode_q;
    assign cal_src    = phase_source(phase);

    always_comb begin
        case (phase)
            PH_SELF_ZERO: target = CW'(SELF_ZERO_LEN);
            PH_SELF_FULL: target = CW'(SELF_FULL_LEN);
            PH_SYS_ZERO,
            PH_SYS_FULL:  target = CW'(SYS_LEN);
            PH_TAIL:      target = tail_self ? CW'(SELF_TAIL_LEN) : CW'(SYS_TAIL_LEN);
            default:      target = CW'(1);
        endcase
    end

    always_comb begin
        we = '0;
        if (!accept) begin
            case (phase)
                PH_IDLE:      we.data_we = rate_tick;
                PH_SELF_ZERO,
                PH_SYS_ZERO:  we.zero_we = done;
                PH_SELF_FULL,
                PH_SYS_FULL:  we.full_we = done;
                PH_TAIL:      we.data_we = done;
                default:      we = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_RUN;
            phase     <= PH_IDLE;
            tail_self <= 1'b0;
        end else if (accept) begin
            mode_q <= cal_mode_e'(mode_wdata);
            phase  <= entry_phase(cal_mode_e'(mode_wdata));
        end else if (done) begin
            case (phase)
                PH_SELF_ZERO: phase <= PH_SELF_FULL;
                PH_SELF_FULL: begin
                    mode_q    <= MODE_RUN;
                    phase     <= PH_TAIL;
                    tail_self <= 1'b1;
                end
                PH_SYS_ZERO,
                PH_SYS_FULL: begin
                    mode_q    <= MODE_RUN;
                    phase     <= PH_TAIL;
                    tail_self <= 1'b0;
                end
                PH_TAIL:      phase <= PH_IDLE;
                default:      phase <= phase;
            endcase
        end
    end
endmodule

// File: rtl/coef_regs.sv
module coef_regs
    import calseq_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_we_t       we,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] zero_coef,
    output logic [DW-1:0] full_coef,
    output logic [DW-1:0] data_word
);
    logic [NUM_SLOTS-1:0] we_vec;
    logic [DW-1:0]        slot [NUM_SLOTS];

    assign we_vec = {we.data_we, we.full_we, we.zero_we};

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)            slot[i] <= '0;
            else if (we_vec[i]) slot[i] <= result;
        end
    end

    assign zero_coef = slot[0];
    assign full_coef = slot[1];
    assign data_word = slot[2];
endmodule

// File: rtl/rdy_gen.sv
module rdy_gen (
    input  logic clk,
    input  logic rst,
    input  logic raise_req,
    input  logic mod_tick,
    input  logic drop,
    output logic rdy_n
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_n   <= 1'b1;
            pending <= 1'b0;
        end else if (drop) begin
            rdy_n   <= 1'b0;
            pending <= 1'b0;
        end else if ((raise_req || pending) && mod_tick) begin
            rdy_n   <= 1'b1;
            pending <= 1'b0;
        end else if (raise_req) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
    import calseq_pkg::*;
#(
    parameter int DW            = 16,
    parameter int SELF_ZERO_LEN = 3,
    parameter int SELF_FULL_LEN = 3,
    parameter int SYS_LEN       = 3,
    parameter int SELF_TAIL_LEN = 3,
    parameter int SYS_TAIL_LEN  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rate_tick,
    input  logic          mod_tick,
    input  logic          mode_wr,
    input  logic [1:0]    mode_wdata,
    input  logic [DW-1:0] conv_result,
    output logic [1:0]    mode_field,
    output logic [1:0]    cal_src,
    output logic          rdy_n,
    output logic [DW-1:0] zero_coef,
    output logic [DW-1:0] full_coef,
    output logic [DW-1:0] data_word
);
    localparam int MAX_LEN = max_of(max_of(max_of(SELF_ZERO_LEN, SELF_FULL_LEN),
                                           max_of(SYS_LEN, SELF_TAIL_LEN)), SYS_TAIL_LEN);
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic          accept;
    logic          timer_clr;
    logic          done;
    logic [CW-1:0] target;
    reg_we_t       we;

    phase_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (timer_clr),
        .tick   (rate_tick),
        .target (target),
        .done   (done)
    );

    cal_fsm #(
        .SELF_ZERO_LEN (SELF_ZERO_LEN),
        .SELF_FULL_LEN (SELF_FULL_LEN),
        .SYS_LEN       (SYS_LEN),
        .SELF_TAIL_LEN (SELF_TAIL_LEN),
        .SYS_TAIL_LEN  (SYS_TAIL_LEN),
        .CW            (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rate_tick  (rate_tick),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .done       (done),
        .accept     (accept),
        .timer_clr  (timer_clr),
        .target     (target),
        .we         (we),
        .mode_field (mode_field),
        .cal_src    (cal_src)
    );

    coef_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .result    (conv_result),
        .zero_coef (zero_coef),
        .full_coef (full_coef),
        .data_word (data_word)
    );

    rdy_gen u_rdy (
        .clk       (clk),
        .rst       (rst),
        .raise_req (accept),
        .mod_tick  (mod_tick),
        .drop      (we.data_we),
        .rdy_n     (rdy_n)
    );
endmodule

// File: rtl/calseq_checker.sv
module calseq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          rate_tick,
    input logic          mod_tick,
    input logic [1:0]    mode_field,
    input logic          rdy_n,
    input logic [DW-1:0] zero_coef,
    input logic [DW-1:0] full_coef,
    input logic [DW-1:0] data_word
);
    // R8: data-ready only rises on a modulator-cycle boundary
    assert_rdy_rise_on_mod_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_n) |-> $past(mod_tick));

    // R5 / R6: data-ready only falls when a filter word completes
    assert_rdy_fall_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $past(rate_tick));

    // R3: a non-zero mode field changes only by clearing
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_field) != 2'b00 && mode_field != $past(mode_field)) |-> mode_field == 2'b00);

    // R7: the two coefficient registers never update together
    assert_coef_isolation_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(zero_coef) |-> $stable(full_coef));

    // R2: a new data word is always announced by data-ready
    assert_data_with_rdy_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_word) |-> !rdy_n);
endmodule

bind cal_seq_ctrl calseq_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_tick  (rate_tick),
    .mod_tick   (mod_tick),
    .mode_field (mode_field),
    .rdy_n      (rdy_n),
    .zero_coef  (zero_coef),
    .full_coef  (full_coef),
    .data_word  (data_word)
);

// File: tb/sim_cal_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cal_seq_ctrl;
    localparam int DW      = 16;
    localparam int MOD_DIV = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rate_tick = 1'b0;
    logic          mod_tick = 1'b0;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_wdata = 2'b00;
    logic [DW-1:0] conv_result = '0;
    logic [1:0]    mode_field;
    logic [1:0]    cal_src;
    logic          rdy_n;
    logic [DW-1:0] zero_coef;
    logic [DW-1:0] full_coef;
    logic [DW-1:0] data_word;

    int n_chk = 0;
    int n_err = 0;
    int mphase = 0;
    int salt = 0;
    logic last_mod = 1'b0;
    logic [DW-1:0] exp_zero = '0;
    logic [DW-1:0] exp_full = '0;
    logic [DW-1:0] exp_data = '0;

    always #10 clk = ~clk;

    cal_seq_ctrl #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .rate_tick(rate_tick), .mod_tick(mod_tick),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .conv_result(conv_result),
        .mode_field(mode_field), .cal_src(cal_src), .rdy_n(rdy_n),
        .zero_coef(zero_coef), .full_coef(full_coef), .data_word(data_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [1:0] d, input logic [DW-1:0] r);
        rate_tick   = t;
        mode_wr     = w;
        mode_wdata  = d;
        conv_result = r;
        mod_tick    = (mphase == 0);
        last_mod    = (mphase == 0);
        mphase      = (mphase + 1) % MOD_DIV;
        @(posedge clk);
        @(negedge clk);
        rate_tick = 1'b0;
        mode_wr   = 1'b0;
        mod_tick  = 1'b0;
    endtask

    task automatic normal_tick();
        logic [DW-1:0] v;
        salt++;
        v = DW'(16'h5A00 + salt * 7);
        step(1'b1, 1'b0, 2'b00, v);
        exp_data = v;
        chk("R2 data", 32'(data_word), 32'(exp_data));
        chk("R2 rdy_n", 32'(rdy_n), 32'd0);
    endtask

    task automatic run_cal(input logic [1:0] mode, input int upto, input logic with_tick);
        int n_cal;
        int n_tot;
        logic prev_rdy;
        logic seen;
        logic [DW-1:0] v;
        logic [1:0] esrc;
        n_cal    = (mode == 2'b01) ? 6 : 3;
        n_tot    = (mode == 2'b01) ? 9 : 4;
        prev_rdy = rdy_n;
        salt++;
        step(with_tick, 1'b1, mode, DW'(16'hEE00 + salt));
        seen = last_mod;
        chk("R3 mode accepted", 32'(mode_field), 32'(mode));
        chk("R9 data not loaded", 32'(data_word), 32'(exp_data));
        chk("R8 rdy_n on accept", 32'(rdy_n), 32'(seen ? 1'b1 : prev_rdy));
        while (!seen) begin
            step(1'b0, 1'b0, 2'b00, '0);
            seen = last_mod;
            chk("R8 rdy_n waits for mod", 32'(rdy_n), 32'(seen ? 1'b1 : prev_rdy));
        end
        for (int k = 1; k <= upto; k++) begin
            if (mode == 2'b01 && k <= 3)      esrc = 2'b01;
            else if (mode == 2'b01 && k <= 6) esrc = 2'b10;
            else                              esrc = 2'b00;
            chk("R4/R6 cal_src", 32'(cal_src), 32'(esrc));
            if (k < n_cal) begin
                step(1'b0, 1'b1, mode ^ 2'b11, '0);
                chk("R3 write ignored", 32'(mode_field), 32'(mode));
            end else begin
                step(1'b0, 1'b0, 2'b00, '0);
            end
            v = DW'(mode * 16'h1111 + k * 16'h0101 + salt * 3);
            step(1'b1, 1'b0, 2'b00, v);
            if ((mode == 2'b01 && k == 3) || (mode == 2'b10 && k == 3)) exp_zero = v;
            if ((mode == 2'b01 && k == 6) || (mode == 2'b11 && k == 3)) exp_full = v;
            if (k == n_tot) exp_data = v;
            chk("R4/R6 mode field", 32'(mode_field), 32'((k < n_cal) ? mode : 2'b00));
            chk("R5/R6 rdy_n", 32'(rdy_n), 32'((k < n_tot) ? 1'b1 : 1'b0));
            chk("R7 zero_coef", 32'(zero_coef), 32'(exp_zero));
            chk("R7 full_coef", 32'(full_coef), 32'(exp_full));
            chk("R5 data_word", 32'(data_word), 32'(exp_data));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rdy_n", 32'(rdy_n), 32'd1);
        chk("R1 mode", 32'(mode_field), 32'd0);
        chk("R1 src", 32'(cal_src), 32'd0);
        chk("R1 zero", 32'(zero_coef), 32'd0);
        chk("R1 full", 32'(full_coef), 32'd0);
        chk("R1 data", 32'(data_word), 32'd0);

        for (int i = 0; i < 3; i++) normal_tick();

        // R3: a write of code 00 does nothing
        step(1'b0, 1'b1, 2'b00, '0);
        chk("R3 zero write mode", 32'(mode_field), 32'd0);
        chk("R3 zero write rdy_n", 32'(rdy_n), 32'd0);

        // sweep mode, modulator phase and coincident tick
        for (int m = 1; m <= 3; m++) begin
            for (int off = 0; off < MOD_DIV; off++) begin
                for (int wt = 0; wt < 2; wt++) begin
                    for (int p = 0; p <= off; p++) step(1'b0, 1'b0, 2'b00, '0);
                    run_cal(2'(m), (m == 1) ? 9 : 4, wt[0]);
                    normal_tick();
                end
            end
        end

        // R10: restart after the mode field has cleared
        run_cal(2'b10, 3, 1'b0);
        chk("R10 rdy_n high before restart", 32'(rdy_n), 32'd1);
        run_cal(2'b11, 4, 1'b0);
        normal_tick();
        run_cal(2'b11, 3, 1'b0);
        run_cal(2'b01, 9, 1'b1);
        chk("R10 rdy_n low at end", 32'(rdy_n), 32'd0);
        normal_tick();

        finish_run();
    end
endmodule